// File: doc/BRIEF.md
# Hotplug Slot Status Register Bank

This block tracks device insertion and removal events for up to 32 slots on each of a parameterised number of buses, and presents them to firmware through a small 32-bit register window. Each bus owns three 32-bit bitmaps: newly inserted slots, slots whose removal has been requested, and slots that may be removed. All per-bus registers are reached through a bus-select register. Firmware reads the bitmaps, then ejects a slot by writing a bitmap whose lowest set bit names it. The block answers with a one-cycle eject pulse that carries bus and slot. No pulse is sent for a slot marked as not removable.

Insertion events count only for hot-added devices. A counted event, or any removal event, sets a sticky event-status bit, which drives an interrupt through an enable bit. After a reset, a sequencer visits every bus in turn. It executes each pending removal request, lowest slot first, and then loads the removable mask from a neighbouring lookup that reports the slots that are not hotpluggable. A parameter selects a legacy variant: in it, the insertion bitmap is not cleared by a read and the select register cannot be reached.

Top module: `hp_slot_bank`

## Requirements
- R1: Register offsets: 0x00 inserted bitmap, 0x04 removal-request bitmap, 0x08 eject/features, 0x0C removable mask, 0x10 bus select, 0x14 event status, 0x18 event enable. Read data appears on `reg_rdata` in the cycle after the access and is zero otherwise. An access whose `reg_addr[1:0]` is not zero is ignored and reads zero.
- R2: An insertion event with `ev_hot`=1 sets bit `ev_slot` of the bus's inserted bitmap. An insertion event with `ev_hot`=0 changes no bitmap and no status.
- R3: A removal event (`ev_remove`=1) sets bit `ev_slot` of the bus's removal-request bitmap.
- R4: A read of 0x00 returns the bitmap and clears it, unless LEGACY=1, in which case it stays unchanged. An insertion on the same bus in the same cycle as the clearing read survives the clear.
- R5: A read of 0x08 returns zero.
- R6: A write to 0x08 with nonzero data takes the lowest set bit of the data as a slot number and clears that slot's bit in both the inserted and removal-request bitmaps of the selected bus. Zero data has no effect.
- R7: After an eject write, `eject_valid` is high for exactly the next cycle, with `eject_bus`/`eject_slot` naming the slot, but only if the slot's removable bit is 1.
- R8: While the select value is at or above NUM_BUS: reads at 0x00–0x10 return zero, eject writes are ignored, and no read-clear happens.
- R9: Bit 1 of 0x14 is set by any counted insertion or removal event. Writing 1 to bit 1 clears it. An event in the same cycle wins over the clear.
- R10: `irq` is a registered copy of (status bit AND enable bit 1 of 0x18), so it follows them one cycle later.
- R11: After `rst` or `warm_rst`, a sweep visits buses 0 to NUM_BUS-1, spending one cycle per step. On each bus it ejects pending removals lowest slot first, with a pulse unless `scan_pinned` has that slot's bit set. It then loads the removable mask with ~`scan_pinned` for `scan_bus`. During the sweep, reads at 0x00–0x10 return zero and writes there are ignored.
- R12: With LEGACY=1, offset 0x10 reads zero and ignores writes, so the select value stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all state and starts a sweep |
| warm_rst | input | 1 | Starts a sweep without clearing the bitmaps |
| ev_valid | input | 1 | Hotplug event strobe |
| ev_remove | input | 1 | 1 = removal request, 0 = insertion |
| ev_hot | input | 1 | Insertion is from a hot-added device |
| ev_bus | input | BUS_W | Bus index of the event |
| ev_slot | input | 5 | Slot number of the event |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| scan_bus | output | BUS_W | Bus being swept |
| scan_pinned | input | 32 | Non-hotpluggable slots of `scan_bus` |
| eject_valid | output | 1 | One-cycle eject pulse |
| eject_bus | output | BUS_W | Bus of the ejected slot |
| eject_slot | output | 5 | Ejected slot |
| irq | output | 1 | Interrupt line |

## Verification
Several properties are checked by assertions on every cycle: an event's bit is present after the edge that takes it, an eject clears both bitmaps unless a same-cycle event refills them, a clearing read empties the bitmap, the sweep advances one bus per load step and stops after the last bus, and `irq` is never high without the enable. Other behaviour can only be shown by the bench's directed scenarios. These cover lowest-bit selection among several set bits, suppression of pulses for pinned slots, the order of pulses during a warm sweep, gating of reads and writes while the select value is out of range, and the legacy instance keeping its bitmap across reads.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int SLOTS = 32;
  localparam logic [4:0] OFF_UP   = 5'h00;
  localparam logic [4:0] OFF_DOWN = 5'h04;
  localparam logic [4:0] OFF_EJ   = 5'h08;
  localparam logic [4:0] OFF_RMV  = 5'h0C;
  localparam logic [4:0] OFF_SEL  = 5'h10;
  localparam logic [4:0] OFF_STS  = 5'h14;
  localparam logic [4:0] OFF_EN   = 5'h18;

  // index of the lowest set bit; 0 when none is set (callers gate on v != 0)
  function automatic logic [4:0] hp_low_bit(input logic [31:0] v);
    hp_low_bit = 5'd0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) hp_low_bit = 5'(i);
    end
  endfunction
endpackage

// File: rtl/hp_slot_store.sv
module hp_slot_store #(
  parameter int NUM_BUS = 256,
  parameter int BUS_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  logic             rem_en,
  input  logic [BUS_W-1:0] ev_bus,
  input  logic [4:0]       ev_slot,
  input  logic             rc_en,
  input  logic [BUS_W-1:0] rc_bus,
  input  logic             ej_en,
  input  logic [BUS_W-1:0] ej_bus,
  input  logic [4:0]       ej_slot,
  input  logic             ld_en,
  input  logic [BUS_W-1:0] ld_bus,
  input  logic [31:0]      ld_mask,
  input  logic [BUS_W-1:0] rd_bus,
  output logic [31:0]      rd_up,
  output logic [31:0]      rd_down,
  output logic [31:0]      rd_rmv,
  input  logic [BUS_W-1:0] sw_bus,
  output logic [31:0]      sw_down
);
  logic [31:0] up_q [NUM_BUS];
  logic [31:0] dn_q [NUM_BUS];
  logic [31:0] rm_q [NUM_BUS];
  logic [31:0] up_nx [NUM_BUS];
  logic [31:0] dn_nx [NUM_BUS];
  logic [31:0] rm_nx [NUM_BUS];

  // clear first, then set: a same-cycle event survives a clear or eject
  always_comb begin
    for (int b = 0; b < NUM_BUS; b++) begin
      up_nx[b] = up_q[b];
      dn_nx[b] = dn_q[b];
      rm_nx[b] = rm_q[b];
      if (rc_en && rc_bus == BUS_W'(b)) up_nx[b] = '0;
      if (ej_en && ej_bus == BUS_W'(b)) begin
        up_nx[b][ej_slot] = 1'b0;
        dn_nx[b][ej_slot] = 1'b0;
      end
      if (ins_en && ev_bus == BUS_W'(b)) up_nx[b][ev_slot] = 1'b1;
      if (rem_en && ev_bus == BUS_W'(b)) dn_nx[b][ev_slot] = 1'b1;
      if (ld_en && ld_bus == BUS_W'(b)) rm_nx[b] = ld_mask;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BUS; b++) begin
      if (rst) begin
        up_q[b] <= '0;
        dn_q[b] <= '0;
        rm_q[b] <= '0;
      end else begin
        up_q[b] <= up_nx[b];
        dn_q[b] <= dn_nx[b];
        rm_q[b] <= rm_nx[b];
      end
    end
  end

  assign rd_up   = up_q[rd_bus];
  assign rd_down = dn_q[rd_bus];
  assign rd_rmv  = rm_q[rd_bus];
  assign sw_down = dn_q[sw_bus];

  // history of last cycle's requests, used by the assertions below
  logic             h_ins, h_rem, h_rc, h_rc_new, h_ej, h_ej_new;
  logic [BUS_W-1:0] h_ev_bus, h_rc_bus, h_ej_bus;
  logic [4:0]       h_ev_slot, h_ej_slot;
  always_ff @(posedge clk) begin
    if (rst) begin
      h_ins <= 1'b0; h_rem <= 1'b0; h_rc <= 1'b0; h_rc_new <= 1'b0;
      h_ej <= 1'b0; h_ej_new <= 1'b0;
      h_ev_bus <= '0; h_rc_bus <= '0; h_ej_bus <= '0;
      h_ev_slot <= '0; h_ej_slot <= '0;
    end else begin
      h_ins     <= ins_en;
      h_rem     <= rem_en;
      h_ev_bus  <= ev_bus;
      h_ev_slot <= ev_slot;
      h_rc      <= rc_en;
      h_rc_bus  <= rc_bus;
      h_rc_new  <= ins_en && ev_bus == rc_bus;
      h_ej      <= ej_en;
      h_ej_bus  <= ej_bus;
      h_ej_slot <= ej_slot;
      h_ej_new  <= (ins_en || rem_en) && ev_bus == ej_bus && ev_slot == ej_slot;
    end
  end

  assert_insert_sets_R2: assert property (@(posedge clk) disable iff (rst)
    h_ins |-> up_q[h_ev_bus][h_ev_slot]);
  assert_remove_sets_R3: assert property (@(posedge clk) disable iff (rst)
    h_rem |-> dn_q[h_ev_bus][h_ev_slot]);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (h_rc && !h_rc_new) |-> (up_q[h_rc_bus] == 32'h0));
  assert_eject_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (h_ej && !h_ej_new) |-> (!up_q[h_ej_bus][h_ej_slot] && !dn_q[h_ej_bus][h_ej_slot]));
endmodule

// File: rtl/hp_sweep.sv
module hp_sweep #(
  parameter int NUM_BUS = 256,
  parameter int BUS_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [31:0]      cur_down,
  output logic             active,
  output logic [BUS_W-1:0] bus,
  output logic             ej_en,
  output logic [4:0]       ej_slot,
  output logic             ld_en
);
  import hp_pkg::*;
  localparam logic [BUS_W-1:0] LAST = BUS_W'(NUM_BUS - 1);

  assign ej_en   = active && (cur_down != 32'h0);
  assign ld_en   = active && (cur_down == 32'h0);
  assign ej_slot = hp_low_bit(cur_down);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      active <= 1'b1;
      bus    <= '0;
    end else if (ld_en) begin
      if (bus == LAST) active <= 1'b0;
      else             bus    <= bus + 1'b1;
    end
  end

  assert_sweep_stops_R11: assert property (@(posedge clk) disable iff (rst)
    (ld_en && bus == LAST && !restart) |=> !active);
  assert_sweep_steps_R11: assert property (@(posedge clk) disable iff (rst)
    (ld_en && bus != LAST && !restart) |=> (bus == $past(bus) + 1'b1));
  assert_sweep_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (ej_en && !restart) |=> (active && $stable(bus)));
endmodule

// File: rtl/hp_gpe.sv
module hp_gpe (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_w,
  input  logic en_w,
  input  logic en_d,
  output logic sts,
  output logic en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= 1'b0;
      en  <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (set_ev)     sts <= 1'b1;
      else if (clr_w) sts <= 1'b0;
      if (en_w) en <= en_d;
      irq <= sts & en;
    end
  end

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> sts);
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_w && !set_ev) |=> !sts);
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en));
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank #(
  parameter int NUM_BUS = 256,
  parameter bit LEGACY  = 1'b0,
  localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             warm_rst,
  input  logic             ev_valid,
  input  logic             ev_remove,
  input  logic             ev_hot,
  input  logic [BUS_W-1:0] ev_bus,
  input  logic [4:0]       ev_slot,
  input  logic             reg_cs,
  input  logic             reg_we,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [BUS_W-1:0] scan_bus,
  input  logic [31:0]      scan_pinned,
  output logic             eject_valid,
  output logic [BUS_W-1:0] eject_bus,
  output logic [4:0]       eject_slot,
  output logic             irq
);
  import hp_pkg::*;

  logic [31:0]      sel_q;
  logic             acc, rd, wr, sel_ok, hp_ok;
  logic [BUS_W-1:0] rd_bus;
  logic [31:0]      rd_up, rd_down, rd_rmv, sw_down, rd_next;
  logic             sw_active, sw_ej, sw_ld;
  logic [BUS_W-1:0] sw_bus;
  logic [4:0]       sw_slot, host_slot;
  logic             host_ej, rc_en, ins_en, rem_en;
  logic             sts, en;

  assign acc     = reg_cs && (reg_addr[1:0] == 2'b00);
  assign rd      = acc && !reg_we;
  assign wr      = acc && reg_we;
  assign sel_ok  = sel_q < NUM_BUS;
  assign hp_ok   = !sw_active && sel_ok;
  assign rd_bus  = sel_q[BUS_W-1:0];
  assign ins_en  = ev_valid && !ev_remove && ev_hot;
  assign rem_en  = ev_valid && ev_remove;
  assign rc_en   = rd && (reg_addr == OFF_UP) && hp_ok && !LEGACY;
  assign host_ej = wr && (reg_addr == OFF_EJ) && hp_ok && (reg_wdata != 32'h0);
  assign host_slot = hp_low_bit(reg_wdata);
  assign scan_bus  = sw_bus;

  hp_sweep #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_sweep (
    .clk(clk), .rst(rst), .restart(warm_rst), .cur_down(sw_down),
    .active(sw_active), .bus(sw_bus), .ej_en(sw_ej), .ej_slot(sw_slot),
    .ld_en(sw_ld)
  );

  hp_slot_store #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_store (
    .clk(clk), .rst(rst),
    .ins_en(ins_en), .rem_en(rem_en), .ev_bus(ev_bus), .ev_slot(ev_slot),
    .rc_en(rc_en), .rc_bus(rd_bus),
    .ej_en(host_ej || sw_ej),
    .ej_bus(sw_active ? sw_bus : rd_bus),
    .ej_slot(sw_active ? sw_slot : host_slot),
    .ld_en(sw_ld), .ld_bus(sw_bus), .ld_mask(~scan_pinned),
    .rd_bus(rd_bus), .rd_up(rd_up), .rd_down(rd_down), .rd_rmv(rd_rmv),
    .sw_bus(sw_bus), .sw_down(sw_down)
  );

  hp_gpe u_gpe (
    .clk(clk), .rst(rst), .set_ev(ins_en || rem_en),
    .clr_w(wr && (reg_addr == OFF_STS) && reg_wdata[1]),
    .en_w(wr && (reg_addr == OFF_EN)), .en_d(reg_wdata[1]),
    .sts(sts), .en(en), .irq(irq)
  );

  always_comb begin
    rd_next = 32'h0;
    unique case (reg_addr)
      OFF_UP:   if (hp_ok) rd_next = rd_up;
      OFF_DOWN: if (hp_ok) rd_next = rd_down;
      OFF_RMV:  if (hp_ok) rd_next = rd_rmv;
      OFF_SEL:  if (hp_ok && !LEGACY) rd_next = sel_q;
      OFF_STS:  rd_next = {30'h0, sts, 1'b0};
      OFF_EN:   rd_next = {30'h0, en, 1'b0};
      default:  rd_next = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      reg_rdata   <= '0;
      eject_valid <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
    end else begin
      reg_rdata <= rd ? rd_next : 32'h0;
      if (wr && reg_addr == OFF_SEL && !LEGACY && !sw_active) sel_q <= reg_wdata;
      if (host_ej) begin
        eject_valid <= rd_rmv[host_slot];
        eject_bus   <= rd_bus;
        eject_slot  <= host_slot;
      end else if (sw_ej) begin
        eject_valid <= !scan_pinned[sw_slot];
        eject_bus   <= sw_bus;
        eject_slot  <= sw_slot;
      end else begin
        eject_valid <= 1'b0;
      end
    end
  end

  assert_pulse_removable_R7: assert property (@(posedge clk) disable iff (rst)
    (host_ej && rd_rmv[host_slot]) |=> (eject_valid && eject_slot == $past(host_slot)));
  assert_pulse_once_R7: assert property (@(posedge clk) disable iff (rst)
    (host_ej && !warm_rst) |=> ##1 !eject_valid || $past(sw_ej || host_ej));
  assert_range_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && reg_addr == OFF_EJ && !sel_ok && !sw_active) |=> !eject_valid);

  if (LEGACY) begin : g_leg
    assert_legacy_sel_R12: assert property (@(posedge clk) disable iff (rst)
      sel_q == 32'h0);
  end
endmodule

// File: tb/sim_hp_slot_bank.sv
module sim_hp_slot_bank;
  logic clk = 1'b0;
  logic rst = 1'b1, warm_rst = 1'b0;
  logic ev_valid = 1'b0, ev_remove = 1'b0, ev_hot = 1'b0;
  logic [1:0] ev_bus = '0;
  logic [4:0] ev_slot = '0;
  logic reg_cs = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_l, pin, pin_l;
  logic [1:0] scan_bus, scan_bus_l, ej_bus, ej_bus_l;
  logic ej_valid, ej_valid_l, irq, irq_l;
  logic [4:0] ej_slot, ej_slot_l;

  int checks = 0, errors = 0, np = 0;
  int pb [16];
  int ps [16];

  always #5 clk = ~clk;

  assign pin   = (scan_bus   == 2'd1) ? 32'h4 : 32'h0;
  assign pin_l = (scan_bus_l == 2'd1) ? 32'h4 : 32'h0;

  hp_slot_bank #(.NUM_BUS(4), .LEGACY(1'b0)) u0 (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .ev_valid(ev_valid),
    .ev_remove(ev_remove), .ev_hot(ev_hot), .ev_bus(ev_bus), .ev_slot(ev_slot),
    .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .scan_bus(scan_bus), .scan_pinned(pin),
    .eject_valid(ej_valid), .eject_bus(ej_bus), .eject_slot(ej_slot), .irq(irq));

  hp_slot_bank #(.NUM_BUS(4), .LEGACY(1'b1)) u_leg (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .ev_valid(ev_valid),
    .ev_remove(ev_remove), .ev_hot(ev_hot), .ev_bus(ev_bus), .ev_slot(ev_slot),
    .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_l), .scan_bus(scan_bus_l), .scan_pinned(pin_l),
    .eject_valid(ej_valid_l), .eject_bus(ej_bus_l), .eject_slot(ej_slot_l), .irq(irq_l));

  // eject pulse log for u0
  always @(negedge clk) begin
    if (ej_valid) begin
      if (np < 16) begin
        pb[np] = int'(ej_bus);
        ps[np] = int'(ej_slot);
      end
      np++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v, output logic [31:0] vl);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    v = rdata; vl = rdata_l;
    reg_cs = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0;
  endtask

  task automatic ev(input logic rem, input logic hot, input logic [1:0] b, input logic [4:0] s);
    @(negedge clk);
    ev_valid = 1'b1; ev_remove = rem; ev_hot = hot; ev_bus = b; ev_slot = s;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v, vl;
    rd(5'h00, v, vl); chk("R1 reset inserted", v, 32'h0);
    rd(5'h04, v, vl); chk("R1 reset removal", v, 32'h0);
    rd(5'h0C, v, vl); chk("R11 reset removable bus0", v, 32'hFFFF_FFFF);
    rd(5'h14, v, vl); chk("R9 reset status", v, 32'h0);
    chk("R10 reset irq", {31'h0, irq}, 32'h0);
    chk("R7 no pulse after reset", np, 0);
  endtask

  task automatic t_insert;
    logic [31:0] v, vl;
    wr(5'h10, 32'h0);
    ev(1'b0, 1'b1, 2'd0, 5'd3);
    ev(1'b0, 1'b0, 2'd0, 5'd9);
    rd(5'h14, v, vl); chk("R9 status set by hot insert", v, 32'h2);
    rd(5'h00, v, vl); chk("R2 hot insert only", v, 32'h8);
    rd(5'h00, v, vl); chk("R4 read clears", v, 32'h0);
    wr(5'h14, 32'h2);
    rd(5'h14, v, vl); chk("R9 write-one clears", v, 32'h0);
    ev(1'b0, 1'b0, 2'd0, 5'd9);
    rd(5'h14, v, vl); chk("R2 cold insert sets no status", v, 32'h0);
  endtask

  task automatic t_remove;
    logic [31:0] v, vl;
    ev(1'b1, 1'b0, 2'd2, 5'd31);
    wr(5'h10, 32'h2);
    rd(5'h04, v, vl); chk("R3 removal bit", v, 32'h8000_0000);
    rd(5'h00, v, vl); chk("R3 removal leaves inserted", v, 32'h0);
    rd(5'h08, v, vl); chk("R5 features read", v, 32'h0);
    rd(5'h10, v, vl); chk("R1 select readback", v, 32'h2);
  endtask

  task automatic t_eject;
    logic [31:0] v, vl;
    int base;
    ev(1'b1, 1'b0, 2'd2, 5'd4);
    ev(1'b0, 1'b1, 2'd2, 5'd31);
    base = np;
    wr(5'h08, 32'h8000_0010);
    @(negedge clk);
    chk("R7 pulse count lowest", np, base + 1);
    chk("R7 pulse bus", pb[base], 2);
    chk("R6 lowest bit slot", ps[base], 4);
    rd(5'h04, v, vl); chk("R6 removal after first eject", v, 32'h8000_0000);
    wr(5'h08, 32'h8000_0000);
    @(negedge clk);
    chk("R7 second pulse slot", ps[base + 1], 31);
    rd(5'h04, v, vl); chk("R6 removal cleared", v, 32'h0);
    rd(5'h00, v, vl); chk("R6 inserted cleared", v, 32'h0);
    wr(5'h08, 32'h0);
    @(negedge clk);
    chk("R6 zero data no pulse", np, base + 2);
  endtask

  task automatic t_pinned;
    logic [31:0] v, vl;
    int base;
    wr(5'h10, 32'h1);
    rd(5'h0C, v, vl); chk("R11 removable bus1", v, 32'hFFFF_FFFB);
    ev(1'b1, 1'b0, 2'd1, 5'd2);
    base = np;
    wr(5'h08, 32'h4);
    @(negedge clk);
    chk("R7 pinned slot no pulse", np, base);
    rd(5'h04, v, vl); chk("R6 pinned slot still cleared", v, 32'h0);
    ev(1'b1, 1'b0, 2'd1, 5'd3);
    wr(5'h08, 32'h8);
    @(negedge clk);
    chk("R7 removable slot pulse", np, base + 1);
    chk("R7 pulse bus1 slot", pb[base] * 32 + ps[base], 32 + 3);
  endtask

  task automatic t_irq;
    logic [31:0] v, vl;
    wr(5'h14, 32'h2);
    wr(5'h18, 32'h2);
    rd(5'h18, v, vl); chk("R10 enable readback", v, 32'h2);
    chk("R10 irq low without status", {31'h0, irq}, 32'h0);
    ev(1'b0, 1'b1, 2'd0, 5'd1);
    chk("R10 irq lags status", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq raised", {31'h0, irq}, 32'h1);
    wr(5'h18, 32'h0);
    @(negedge clk);
    chk("R10 irq dropped by enable", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h2);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v, vl;
    wr(5'h10, 32'h0);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b0; reg_addr = 5'h00;
    ev_valid = 1'b1; ev_remove = 1'b0; ev_hot = 1'b1; ev_bus = 2'd0; ev_slot = 5'd7;
    @(negedge clk);
    v = rdata;
    reg_cs = 1'b0; ev_valid = 1'b0;
    chk("R4 read returns old bitmap", v, 32'h2);
    rd(5'h00, v, vl); chk("R4 new event survives clear", v, 32'h80);
    @(negedge clk);
    reg_cs = 1'b1; reg_we = 1'b1; reg_addr = 5'h14; reg_wdata = 32'h2;
    ev_valid = 1'b1; ev_remove = 1'b0; ev_hot = 1'b1; ev_bus = 2'd0; ev_slot = 5'd8;
    @(negedge clk);
    reg_cs = 1'b0; reg_we = 1'b0; ev_valid = 1'b0;
    rd(5'h14, v, vl); chk("R9 event wins over clear", v, 32'h2);
    wr(5'h14, 32'h2);
    rd(5'h14, v, vl); chk("R9 cleared afterwards", v, 32'h0);
  endtask

  task automatic t_range;
    logic [31:0] v, vl;
    int base;
    ev(1'b1, 1'b0, 2'd0, 5'd0);
    wr(5'h10, 32'h4);
    base = np;
    rd(5'h00, v, vl); chk("R8 out-of-range inserted read", v, 32'h0);
    rd(5'h04, v, vl); chk("R8 out-of-range removal read", v, 32'h0);
    rd(5'h10, v, vl); chk("R8 out-of-range select read", v, 32'h0);
    wr(5'h08, 32'h1);
    @(negedge clk);
    chk("R8 eject ignored no pulse", np, base);
    wr(5'h10, 32'h0);
    rd(5'h04, v, vl); chk("R8 removal kept", v, 32'h1);
    rd(5'h00, v, vl); chk("R8 no read-clear out of range", v, 32'h100);
    rd(5'h01, v, vl); chk("R1 unaligned read zero", v, 32'h0);
    wr(5'h11, 32'h3);
    rd(5'h10, v, vl); chk("R1 unaligned write ignored", v, 32'h0);
  endtask

  task automatic t_sweep;
    logic [31:0] v, vl;
    int base;
    ev(1'b1, 1'b0, 2'd1, 5'd5);
    ev(1'b1, 1'b0, 2'd1, 5'd2);
    ev(1'b1, 1'b0, 2'd3, 5'd0);
    base = np;
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    rd(5'h0C, v, vl); chk("R11 window reads zero in sweep", v, 32'h0);
    repeat (20) @(negedge clk);
    chk("R11 sweep pulse count", np, base + 3);
    chk("R11 first pulse bus0 slot0", pb[base] * 32 + ps[base], 0);
    chk("R11 second pulse bus1 slot5", pb[base + 1] * 32 + ps[base + 1], 32 + 5);
    chk("R11 third pulse bus3 slot0", pb[base + 2] * 32 + ps[base + 2], 96);
    rd(5'h04, v, vl); chk("R11 bus0 removals done", v, 32'h0);
    wr(5'h10, 32'h1);
    rd(5'h04, v, vl); chk("R11 bus1 removals done", v, 32'h0);
    rd(5'h0C, v, vl); chk("R11 bus1 mask reloaded", v, 32'hFFFF_FFFB);
    wr(5'h10, 32'h3);
    rd(5'h04, v, vl); chk("R11 bus3 removals done", v, 32'h0);
  endtask

  task automatic t_legacy;
    logic [31:0] v, vl;
    wr(5'h10, 32'h2);
    rd(5'h10, v, vl); chk("R12 legacy select unreachable", vl, 32'h0);
    rd(5'h00, v, vl); chk("R4 legacy first read", vl, 32'h182);
    rd(5'h00, v, vl); chk("R4 legacy no clear", vl, 32'h182);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    t_reset();
    t_insert();
    t_remove();
    t_eject();
    t_pinned();
    t_irq();
    t_same_cycle();
    t_range();
    t_sweep();
    t_legacy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule